// File: doc/BRIEF.md
# MDIO Management Slave

This block is the PHY-side end of a clause-22 serial management bus. A station supplies the management clock `mdc` and shares one open-drain data line with up to 32 slaves. The line is modelled here as three signals: an input `mdio_i`, an output value `mdio_o` and an output enable `mdio_oe`. The block samples the line on every rising `mdc` edge and tracks each frame bit by bit. A frame consists of a preamble, a start pattern, an opcode, a PHY address, a register address, a turnaround and a data field. The block serves frames whose PHY address equals its own. Its own address comes from five strap inputs while reset is asserted.

Each matching frame reads or writes one of 32 sixteen-bit registers held in a small internal register bank. For a read, the slave leaves the line alone for the first turnaround bit and drives a zero on the second. It then shifts out the register contents, most significant bit first, and releases the line after the last bit. Nothing happens while `mdc` is stopped. The rising edge that follows reset release is always ignored.

Top module: `mdio_slave`

## Requirements
- R1: The slave's own PHY address is taken from `strap_addr` while `rst_n` is low. Changes on `strap_addr` after reset release have no effect: a frame sent to the new value is not answered.
- R2: The first rising `mdc` edge after `rst_n` goes high is ignored. A write frame whose 32-bit preamble begins on that edge has only 31 preamble bits seen, and it does not change any register.
- R3: A frame is recognised only after at least 32 consecutive ones, followed by a 0 and then a 1, all sampled on rising `mdc` edges. A frame preceded by only 31 ones has no effect.
- R4: After the start pattern, the 2-bit opcode 10 selects a read and 01 selects a write. The opcodes 00 and 11 abandon the frame: the slave never drives the line for it and writes no register.
- R5: The PHY address field is 5 bits, sent MSB first. When it differs from the slave's own address, the slave never asserts `mdio_oe` for that frame and writes no register.
- R6: The 5-bit register address field, sent MSB first, selects one of 32 registers. In a write frame the two turnaround bits come from the station. After them come 16 data bits, MSB first, and the register takes that value once all 16 bits have been received.
- R7: In a read frame the slave keeps `mdio_oe` low during the first turnaround bit. It drives `mdio_oe`=1 with `mdio_o`=0 during the second turnaround bit.
- R8: In a read frame the slave then drives the 16 register bits, MSB first, one per `mdc` period. Each bit is set up after a rising edge and held for the station's sample on the next rising edge.
- R9: `mdio_oe` stays high for exactly 17 `mdc` periods in a read frame (one turnaround bit plus 16 data bits). It is low in the bit period after the last data bit.
- R10: While `rst_n` is low, `mdio_oe` is 0, and all 32 registers read back as 0x0000 after reset.
- R11: `mdc` may stop at any point, whether idle or mid-frame. When it resumes, the frame continues from the bit where it stopped.
- R12: When the bit after a recognised start 0 is another 0 (a lost start), the slave returns to preamble hunting. The rest of that frame, sent without a new preamble, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock from the station; may stop when idle |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | Strap inputs giving the PHY address, captured during reset |
| mdio_i | input | 1 | Sampled state of the shared data line |
| mdio_o | output | 1 | Value the slave drives onto the data line |
| mdio_oe | output | 1 | Enable for the slave's line driver |

## Verification
The hardest situations to reach from the pins are those where the slave should stay silent, because a wrong answer only shows as a missing or unexpected change on a later read. The bench therefore sends a valid-looking write each time the slave should reject it. This covers the write whose preamble starts on the blanked first edge, one with 31 preamble ones, a lost start, a bad opcode and a foreign address. In every case the target register is read back afterwards. The blanked-edge case needs reset released on a falling clock edge, with the first preamble bit already on the line, so that the ignored edge eats exactly one preamble bit. The clock-stop case freezes `mdc` high in the middle of the data field and resumes it later.

// File: rtl/mdio_slave_pkg.sv
`timescale 1ns/1ps
package mdio_slave_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_OPC,
    ST_PHY,
    ST_REG,
    ST_TURN,
    ST_DATA
  } mdio_state_e;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;

  function automatic logic opc_is_rd(input logic [1:0] opc);
    return opc == OPC_RD;
  endfunction

  function automatic logic opc_is_wr(input logic [1:0] opc);
    return opc == OPC_WR;
  endfunction

  // only 01 and 10 are legal: the two bits must differ
  function automatic logic opc_legal(input logic [1:0] opc);
    return opc[1] ^ opc[0];
  endfunction

endpackage

// File: rtl/mdio_strap_latch.sv
`timescale 1ns/1ps
module mdio_strap_latch #(
  parameter int PAW = 5
) (
  input  logic           mdc,
  input  logic           rst_n,
  input  logic [PAW-1:0] strap_addr,
  output logic [PAW-1:0] own_addr,
  output logic           blank
);

  // address follows the straps for as long as reset is held; blank is
  // high until the first edge after release has gone by
  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      own_addr <= strap_addr;
      blank    <= 1'b1;
    end else begin
      blank    <= 1'b0;
    end
  end

endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
  import mdio_slave_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PAW     = 5,
  parameter int RAW     = 5,
  parameter int DW      = 16
) (
  input  logic           mdc,
  input  logic           rst_n,
  input  logic           blank,
  input  logic           mdio_i,
  input  logic [PAW-1:0] own_addr,
  output logic           ev_abort,
  output logic           ev_load,
  output logic           ev_ta_drive,
  output logic           ev_shift,
  output logic           ev_release,
  output logic           wr_en,
  output logic [RAW-1:0] rd_addr,
  output logic [RAW-1:0] wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic           phy_match,
  output logic           op_read
);

  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int BCW = $clog2(DW);
  localparam logic [PCW-1:0] PRE_FULL = PCW'(PRE_LEN);
  localparam logic [BCW-1:0] PHY_LAST = BCW'(PAW - 1);
  localparam logic [BCW-1:0] REG_LAST = BCW'(RAW - 1);
  localparam logic [BCW-1:0] DAT_LAST = BCW'(DW - 1);
  localparam logic [BCW-1:0] TA_LAST  = BCW'(1);

  mdio_state_e    state_q;
  logic [PCW-1:0] pre_cnt_q;
  logic [BCW-1:0] bit_cnt_q;
  logic [1:0]     opc_q;
  logic [PAW-2:0] phy_sr_q;
  logic [RAW-1:0] reg_sr_q;
  logic [DW-2:0]  dat_sr_q;
  logic           match_q;

  logic           step;
  logic [1:0]     opc_full;
  logic [PAW-1:0] phy_full;
  logic [RAW-1:0] reg_full;
  logic           rd_sel;
  logic           wr_sel;

  assign step     = !blank;
  assign opc_full = {opc_q[0], mdio_i};
  assign phy_full = {phy_sr_q, mdio_i};
  assign reg_full = {reg_sr_q[RAW-2:0], mdio_i};
  assign wr_data  = {dat_sr_q, mdio_i};
  assign rd_addr  = reg_full;
  assign wr_addr  = reg_sr_q;
  assign rd_sel   = opc_is_rd(opc_q) && match_q;
  assign wr_sel   = opc_is_wr(opc_q) && match_q;
  assign phy_match = match_q;
  assign op_read   = opc_is_rd(opc_q);

  // named events for the driver, the register bank and the checker
  always_comb begin
    ev_abort    = step && (((state_q == ST_START) && !mdio_i) ||
                           ((state_q == ST_OPC) && (bit_cnt_q == TA_LAST) &&
                            !opc_legal(opc_full)));
    ev_load     = step && (state_q == ST_REG) && (bit_cnt_q == REG_LAST) && rd_sel;
    ev_ta_drive = step && (state_q == ST_TURN) && (bit_cnt_q == '0) && rd_sel;
    ev_shift    = step && rd_sel &&
                  (((state_q == ST_TURN) && (bit_cnt_q == TA_LAST)) ||
                   ((state_q == ST_DATA) && (bit_cnt_q != DAT_LAST)));
    ev_release  = step && rd_sel && (state_q == ST_DATA) && (bit_cnt_q == DAT_LAST);
    wr_en       = step && wr_sel && (state_q == ST_DATA) && (bit_cnt_q == DAT_LAST);
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_HUNT;
      pre_cnt_q <= '0;
      bit_cnt_q <= '0;
      opc_q     <= '0;
      phy_sr_q  <= '0;
      reg_sr_q  <= '0;
      dat_sr_q  <= '0;
      match_q   <= 1'b0;
    end else if (step) begin
      case (state_q)
        ST_HUNT: begin
          if (mdio_i) begin
            if (pre_cnt_q != PRE_FULL) pre_cnt_q <= pre_cnt_q + 1'b1;
          end else begin
            pre_cnt_q <= '0;
            if (pre_cnt_q == PRE_FULL) state_q <= ST_START;
          end
        end
        ST_START: begin
          bit_cnt_q <= '0;
          state_q   <= mdio_i ? ST_OPC : ST_HUNT;
        end
        ST_OPC: begin
          opc_q <= opc_full;
          if (bit_cnt_q == '0) begin
            bit_cnt_q <= TA_LAST;
          end else begin
            bit_cnt_q <= '0;
            state_q   <= opc_legal(opc_full) ? ST_PHY : ST_HUNT;
          end
        end
        ST_PHY: begin
          phy_sr_q <= phy_full[PAW-2:0];
          if (bit_cnt_q == PHY_LAST) begin
            match_q   <= (phy_full == own_addr);
            bit_cnt_q <= '0;
            state_q   <= ST_REG;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_REG: begin
          reg_sr_q <= reg_full;
          if (bit_cnt_q == REG_LAST) begin
            bit_cnt_q <= '0;
            state_q   <= ST_TURN;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_TURN: begin
          if (bit_cnt_q == TA_LAST) begin
            bit_cnt_q <= '0;
            state_q   <= ST_DATA;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          dat_sr_q <= wr_data[DW-2:0];
          if (bit_cnt_q == DAT_LAST) begin
            bit_cnt_q <= '0;
            state_q   <= ST_HUNT;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/mdio_regbank.sv
`timescale 1ns/1ps
module mdio_regbank #(
  parameter int RAW = 5,
  parameter int DW  = 16
) (
  input  logic           mdc,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [RAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data
);

  localparam int NREG = 1 << RAW;

  logic [DW-1:0] word_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n)                                   word_q[g] <= '0;
      else if (wr_en && (wr_addr == RAW'(g)))       word_q[g] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/mdio_tx_drive.sv
`timescale 1ns/1ps
module mdio_tx_drive #(
  parameter int DW = 16
) (
  input  logic          mdc,
  input  logic          rst_n,
  input  logic          ev_load,
  input  logic          ev_ta_drive,
  input  logic          ev_shift,
  input  logic          ev_release,
  input  logic          ev_abort,
  input  logic [DW-1:0] rd_data,
  output logic          mdio_o,
  output logic          mdio_oe
);

  logic [DW-1:0] tx_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (ev_release || ev_abort) begin
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (ev_ta_drive) begin
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b1;
    end else if (ev_shift) begin
      mdio_o  <= tx_q[DW-1];
      tx_q    <= {tx_q[DW-2:0], 1'b0};
    end else if (ev_load) begin
      tx_q    <= rd_data;
    end
  end

endmodule

// File: rtl/mdio_slave.sv
`timescale 1ns/1ps
module mdio_slave #(
  parameter int PRE_LEN = 32,
  parameter int PAW     = 5,
  parameter int RAW     = 5,
  parameter int DW      = 16
) (
  input  logic           mdc,
  input  logic           rst_n,
  input  logic [PAW-1:0] strap_addr,
  input  logic           mdio_i,
  output logic           mdio_o,
  output logic           mdio_oe
);

  logic [PAW-1:0] own_addr;
  logic           blank;
  logic           ev_abort, ev_load, ev_ta_drive, ev_shift, ev_release;
  logic           wr_en, phy_match, op_read;
  logic [RAW-1:0] rd_addr, wr_addr;
  logic [DW-1:0]  wr_data, rd_data;

  mdio_strap_latch #(.PAW(PAW)) u_strap (
    .mdc(mdc), .rst_n(rst_n), .strap_addr(strap_addr),
    .own_addr(own_addr), .blank(blank)
  );

  mdio_frame_fsm #(.PRE_LEN(PRE_LEN), .PAW(PAW), .RAW(RAW), .DW(DW)) u_fsm (
    .mdc(mdc), .rst_n(rst_n), .blank(blank), .mdio_i(mdio_i), .own_addr(own_addr),
    .ev_abort(ev_abort), .ev_load(ev_load), .ev_ta_drive(ev_ta_drive),
    .ev_shift(ev_shift), .ev_release(ev_release), .wr_en(wr_en),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data),
    .phy_match(phy_match), .op_read(op_read)
  );

  mdio_regbank #(.RAW(RAW), .DW(DW)) u_bank (
    .mdc(mdc), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  mdio_tx_drive #(.DW(DW)) u_tx (
    .mdc(mdc), .rst_n(rst_n), .ev_load(ev_load), .ev_ta_drive(ev_ta_drive),
    .ev_shift(ev_shift), .ev_release(ev_release), .ev_abort(ev_abort),
    .rd_data(rd_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

endmodule

// File: rtl/mdio_slave_chk.sv
`timescale 1ns/1ps
module mdio_slave_chk #(
  parameter int DW = 16
) (
  input logic mdc,
  input logic rst_n,
  input logic mdio_o,
  input logic mdio_oe,
  input logic phy_match,
  input logic op_read,
  input logic wr_en,
  input logic ev_abort
);

  logic [7:0] oe_len_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)       oe_len_q <= '0;
    else if (mdio_oe) oe_len_q <= oe_len_q + 1'b1;
    else              oe_len_q <= '0;
  end

  p_ta2_zero_r7: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  p_drive_only_match_r5: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> phy_match);

  p_drive_only_read_r4: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> op_read);

  p_abort_quiet_r4: assert property (@(posedge mdc) disable iff (!rst_n)
    ev_abort |=> !mdio_oe);

  p_write_needs_match_r6: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_en |-> phy_match && !op_read);

  p_drive_window_r9: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> (oe_len_q == 8'(DW + 1)));

  p_write_no_drive_r6: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_en |=> !mdio_oe);

endmodule

bind mdio_slave mdio_slave_chk #(.DW(DW)) u_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .phy_match(phy_match), .op_read(op_read), .wr_en(wr_en), .ev_abort(ev_abort)
);

// File: tb/mdio_slave_tb.sv
`timescale 1ns/1ps
module mdio_slave_tb;

  localparam logic [4:0] OWN   = 5'h0B;
  localparam logic [4:0] OTHER = 5'h0A;

  logic       mdc = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic [4:0] strap = OWN;
  logic       st_en = 1'b0;
  logic       st_val = 1'b1;
  logic       mdio_o, mdio_oe;
  wire        mdio_line;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;

  assign mdio_line = mdio_oe ? mdio_o : (st_en ? st_val : 1'b1);

  mdio_slave u_dut (
    .mdc(mdc), .rst_n(rst_n), .strap_addr(strap),
    .mdio_i(mdio_line), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  initial forever begin
    #10;
    if (clk_run) mdc = ~mdc;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge mdc);
      st_en  = 1'b1;
      st_val = v[i];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge mdc);
      st_en = 1'b0;
    end
  endtask

  task automatic send_hdr(input logic [1:0] opc, input logic [4:0] phy,
                          input logic [4:0] ra, input int pre_n);
    drive_bits(32'hFFFF_FFFF, pre_n);
    drive_bits(32'b01, 2);
    drive_bits({30'b0, opc}, 2);
    drive_bits({27'b0, phy}, 5);
    drive_bits({27'b0, ra}, 5);
  endtask

  task automatic wr_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    send_hdr(2'b01, phy, ra, 32);
    drive_bits(32'b10, 2);
    drive_bits({16'b0, d}, 16);
    idle(1);
  endtask

  task automatic rel_slot(output logic b, output logic oe);
    @(negedge mdc);
    st_en = 1'b0;
    #1;
    b  = mdio_line;
    oe = mdio_oe;
  endtask

  // read frame; returns data and the driver state seen in each bit period
  task automatic rd_frame(input logic [4:0] phy, input logic [4:0] ra,
                          output logic [15:0] d, output logic ta1_oe,
                          output logic ta2_oe, output logic ta2_v,
                          output logic dat_oe, output logic post_oe,
                          output logic any_oe);
    logic b, oe;
    send_hdr(2'b10, phy, ra, 32);
    rel_slot(b, ta1_oe);
    rel_slot(ta2_v, ta2_oe);
    dat_oe = 1'b1;
    any_oe = ta1_oe | ta2_oe;
    for (int i = 15; i >= 0; i--) begin
      rel_slot(b, oe);
      d[i]   = b;
      dat_oe = dat_oe & oe;
      any_oe = any_oe | oe;
    end
    rel_slot(b, post_oe);
    any_oe = any_oe | post_oe;
  endtask

  task automatic rd_value(input logic [4:0] ra, output logic [15:0] d);
    logic a, b2, c, e, f, g;
    rd_frame(OWN, ra, d, a, b2, c, e, f, g);
  endtask

  task automatic t_reset_blank;
    logic [15:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge mdc);
    chk("R10", "oe in reset", int'(mdio_oe), 0);
    // first preamble one sits on the ignored edge, so only 31 count
    @(negedge mdc);
    rst_n  = 1'b1;
    st_en  = 1'b1;
    st_val = 1'b1;
    drive_bits(32'hFFFF_FFFF, 31);
    drive_bits(32'b01, 2);
    drive_bits(32'b01, 2);
    drive_bits({27'b0, OWN}, 5);
    drive_bits(32'd3, 5);
    drive_bits(32'b10, 2);
    drive_bits(32'h1234, 16);
    idle(2);
    strap = 5'h14;
    rd_value(5'd3, d);
    chk("R2", "reg3 after blanked write", int'(d), 0);
    rd_value(5'd0, d);
    chk("R10", "reg0 after reset", int'(d), 0);
    rd_value(5'd31, d);
    chk("R10", "reg31 after reset", int'(d), 0);
  endtask

  task automatic t_strap;
    logic [15:0] d;
    logic a, b2, c, e, f, any;
    rd_frame(5'h14, 5'd0, d, a, b2, c, e, f, any);
    chk("R1", "no drive for post-reset strap value", int'(any), 0);
    wr_frame(5'h14, 5'd1, 16'hBEEF);
    rd_value(5'd1, d);
    chk("R1", "write to post-reset strap value ignored", int'(d), 0);
  endtask

  task automatic rw_check(input logic [4:0] ra, input logic [15:0] v);
    logic [15:0] d;
    logic ta1, ta2, ta2v, doe, post, any;
    wr_frame(OWN, ra, v);
    rd_frame(OWN, ra, d, ta1, ta2, ta2v, doe, post, any);
    chk("R6", $sformatf("reg%0d write/read", ra), int'(d), int'(v));
    chk("R7", "ta1 released", int'(ta1), 0);
    chk("R7", "ta2 driven", int'(ta2), 1);
    chk("R7", "ta2 value zero", int'(ta2v), 0);
    chk("R8", "driver on for all data bits", int'(doe), 1);
    chk("R9", "released after last bit", int'(post), 0);
  endtask

  task automatic t_basic;
    rw_check(5'd5, 16'hA5C3);
    rw_check(5'd0, 16'hFFFF);
    rw_check(5'd31, 16'h8001);
    rw_check(5'd17, 16'h0000);
  endtask

  task automatic t_mismatch;
    logic [15:0] d;
    logic a, b2, c, e, f, any;
    wr_frame(OTHER, 5'd5, 16'h0000);
    rd_value(5'd5, d);
    chk("R5", "foreign write ignored", int'(d), 16'hA5C3);
    rd_frame(OTHER, 5'd5, d, a, b2, c, e, f, any);
    chk("R5", "foreign read not driven", int'(any), 0);
  endtask

  task automatic t_badop(input logic [1:0] opc);
    logic [15:0] d;
    logic b, oe, any;
    any = 1'b0;
    send_hdr(opc, OWN, 5'd5, 32);
    for (int i = 0; i < 19; i++) begin
      rel_slot(b, oe);
      any = any | oe;
    end
    chk("R4", $sformatf("opcode %0b not driven", opc), int'(any), 0);
    send_hdr(opc, OWN, 5'd5, 32);
    drive_bits(32'b10, 2);
    drive_bits(32'h1111, 16);
    idle(1);
    rd_value(5'd5, d);
    chk("R4", $sformatf("opcode %0b no write", opc), int'(d), 16'hA5C3);
  endtask

  task automatic t_short_pre;
    logic [15:0] d;
    drive_bits(32'b00, 2);
    send_hdr(2'b01, OWN, 5'd5, 31);
    drive_bits(32'b10, 2);
    drive_bits(32'h2222, 16);
    idle(1);
    rd_value(5'd5, d);
    chk("R3", "31-one preamble ignored", int'(d), 16'hA5C3);
  endtask

  task automatic t_lost_start;
    logic [15:0] d;
    drive_bits(32'hFFFF_FFFF, 32);
    drive_bits(32'b00, 2);
    drive_bits(32'b01, 2);
    drive_bits({27'b0, OWN}, 5);
    drive_bits(32'd5, 5);
    drive_bits(32'b10, 2);
    drive_bits(32'h3333, 16);
    idle(1);
    rd_value(5'd5, d);
    chk("R12", "lost start drops frame", int'(d), 16'hA5C3);
  endtask

  task automatic pause_clock;
    @(posedge mdc);
    #5 clk_run = 1'b0;
    #400 clk_run = 1'b1;
  endtask

  task automatic t_clock_stop;
    logic [15:0] d;
    pause_clock();
    send_hdr(2'b01, OWN, 5'd7, 32);
    drive_bits(32'b10, 2);
    drive_bits(32'h5A, 8);
    pause_clock();
    drive_bits(32'h5A, 8);
    idle(1);
    rd_value(5'd7, d);
    chk("R11", "write across clock stop", int'(d), 16'h5A5A);
  endtask

  initial begin
    t_reset_blank();
    t_strap();
    t_basic();
    t_mismatch();
    t_badop(2'b00);
    t_badop(2'b11);
    t_short_pre();
    t_lost_start();
    t_clock_stop();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule